// File: doc/BRIEF.md
# Keyed Watchdog Reset Timer

This block is a watchdog that drives a system reset pulse when its down-counter runs out. Software reaches three registers over a simple write bus with a combinational read path. The registers are an unlock register, a load register that holds the live counter, and a control register with two enable bits. The load and control registers only take writes after the unlock word has been written. Any other word written to the unlock register locks them again.

When counting is enabled, the counter steps down once per clock and stops at zero. When counting and reset are both enabled and the counter is zero, the block fires a reset pulse of fixed length. Writing zero to the load register while both enables are set therefore gives a reset one cycle later. At the end of the pulse every register returns to its reset state. Bus writes are ignored while the pulse is active.

Top module: `keyed_wdt`

## Requirements
- R1: After the synchronous reset the block is locked, the counter is 0, both enables are clear and `wdt_rst_o` is low; reads of addresses 0, 1 and 2 return 0.
- R2: Writing exactly 0x0000482E to address 0 unlocks the block, and writing any other word there locks it. A read of address 0 returns the unlocked state in bit 0 and 0 in all other bits.
- R3: While the block is locked, writes to address 1 (load) and address 2 (control) are ignored and leave their contents unchanged.
- R4: In the control register, bit 0 is reset enable and bit 2 is count enable. All other bits are not stored and read as 0.
- R5: A read of address 1 returns the live counter. While count enable is set, the counter falls by one per cycle and holds at 0. A load write sets the counter, and it takes priority over the decrement in the same cycle.
- R6: While count enable is clear, the counter holds its value.
- R7: When both enables are set and the counter is 0, `wdt_rst_o` rises on the next clock edge. If the counter is loaded with N and the enables are written after that, the pulse starts N+1 cycles after the enable write. Loading 0 while both enables are set gives the pulse one cycle later.
- R8: No pulse occurs at counter 0 while either enable is clear.
- R9: `wdt_rst_o` stays high for exactly PULSE_LEN (default 4) cycles, and every bus write during the pulse is ignored.
- R10: On the cycle after the pulse ends, the block is back in its reset state: locked, counter 0 and enables clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 2 | Register select: 0 unlock, 1 load/counter, 2 control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| wdt_rst_o | output | 1 | System reset pulse |

## Verification
The bench builds the block with CNT_W = 8 and leaves PULSE_LEN at 4 and the key at its default. The narrow counter makes an exhaustive sweep of every load value from 0 to 255 affordable. For each value the bench checks the exact cycle at which the pulse starts, the pulse width and the cleared state afterwards. The same build also covers truncation of wide load words, rejection of near-miss keys, the interaction of the two enables at zero, and writes issued while the pulse is active.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    localparam int BUS_W      = 32;
    localparam int BIT_RST_EN = 0;
    localparam int BIT_CNT_EN = 2;

    typedef enum logic [1:0] {
        SEL_UNLOCK = 2'd0,
        SEL_LOAD   = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic cnt_en;
        logic rst_en;
    } ctrl_t;

    function automatic reg_sel_e decode_sel(input logic [1:0] a);
        case (a)
            2'd0:    return SEL_UNLOCK;
            2'd1:    return SEL_LOAD;
            2'd2:    return SEL_CTRL;
            default: return SEL_NONE;
        endcase
    endfunction

    function automatic ctrl_t ctrl_from_word(input logic [BUS_W-1:0] w);
        ctrl_t c;
        c.cnt_en = w[BIT_CNT_EN];
        c.rst_en = w[BIT_RST_EN];
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [BUS_W-1:0] w;
        w = '0;
        w[BIT_CNT_EN] = c.cnt_en;
        w[BIT_RST_EN] = c.rst_en;
        return w;
    endfunction

endpackage

// File: rtl/kwd_lock.sv
module kwd_lock
    import kwd_pkg::*;
#(
    parameter logic [BUS_W-1:0] KEY_VAL = 32'h0000_482E
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             key_wr,
    input  logic [BUS_W-1:0] wdata,
    output logic             unlocked
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            unlocked <= 1'b0;
        end else if (key_wr) begin
            unlocked <= (wdata == KEY_VAL);
        end
    end

    // R2: a locked block stays locked until a key write arrives
    a_r2_stay_locked: assert property (@(posedge clk) disable iff (rst)
        (!unlocked && !key_wr) |=> !unlocked);

    // R2: a wrong word relocks
    a_r2_wrong_key_locks: assert property (@(posedge clk) disable iff (rst)
        (key_wr && wdata != KEY_VAL) |=> !unlocked);

endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic [CNT_W-1:0] count,
    output logic             at_zero
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (run && count != '0) begin
            count <= count - CNT_W'(1);
        end
    end

    assign at_zero = (count == '0);

    // R5: one step down per running cycle
    a_r5_decrement: assert property (@(posedge clk) disable iff (rst)
        (run && !load && !clr && count != '0) |=> (count == $past(count) - CNT_W'(1)));

    // R6: counter holds when not running
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (!run && !load && !clr) |=> $stable(count));

endmodule

// File: rtl/kwd_pulse.sv
module kwd_pulse #(
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic active,
    output logic done
);

    localparam int PW = $clog2(PULSE_LEN + 1);

    logic [PW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
        end else if (left != '0) begin
            left <= left - PW'(1);
        end else if (fire) begin
            left <= PW'(PULSE_LEN);
        end
    end

    assign active = (left != '0);
    assign done   = (left == PW'(1));

    // R7: a trigger while idle starts the pulse on the next edge
    a_r7_start: assert property (@(posedge clk) disable iff (rst)
        (fire && !active) |=> active);

    // R9: the pulse does not end before its last cycle
    a_r9_hold_high: assert property (@(posedge clk) disable iff (rst)
        (active && !done) |=> active);

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import kwd_pkg::*;
#(
    parameter int               CNT_W     = 32,
    parameter int               PULSE_LEN = 4,
    parameter logic [BUS_W-1:0] KEY_VAL   = 32'h0000_482E
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             wdt_rst_o
);

    reg_sel_e         sel;
    logic             unlocked;
    logic             pulse_active;
    logic             pulse_done;
    logic             key_wr;
    logic             prot_wr;
    logic             load;
    logic             ctrl_wr;
    logic             at_zero;
    logic             terminal;
    logic [CNT_W-1:0] count;
    ctrl_t            ctrl;

    assign sel     = decode_sel(bus_addr);
    assign key_wr  = bus_we && !pulse_active && (sel == SEL_UNLOCK);
    assign prot_wr = bus_we && !pulse_active && unlocked;
    assign load    = prot_wr && (sel == SEL_LOAD);
    assign ctrl_wr = prot_wr && (sel == SEL_CTRL);

    kwd_lock #(.KEY_VAL(KEY_VAL)) lock_i (
        .clk      (clk),
        .rst      (rst),
        .clr      (pulse_done),
        .key_wr   (key_wr),
        .wdata    (bus_wdata),
        .unlocked (unlocked)
    );

    always_ff @(posedge clk) begin
        if (rst || pulse_done) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl <= ctrl_from_word(bus_wdata);
        end
    end

    kwd_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst      (rst),
        .clr      (pulse_done),
        .load     (load),
        .load_val (bus_wdata[CNT_W-1:0]),
        .run      (ctrl.cnt_en && !pulse_active),
        .count    (count),
        .at_zero  (at_zero)
    );

    assign terminal = ctrl.cnt_en && ctrl.rst_en && at_zero;

    kwd_pulse #(.PULSE_LEN(PULSE_LEN)) pulse_i (
        .clk    (clk),
        .rst    (rst),
        .fire   (terminal),
        .active (pulse_active),
        .done   (pulse_done)
    );

    assign wdt_rst_o = pulse_active;

    always_comb begin
        case (sel)
            SEL_UNLOCK: bus_rdata = {{(BUS_W-1){1'b0}}, unlocked};
            SEL_LOAD:   bus_rdata = BUS_W'(count);
            SEL_CTRL:   bus_rdata = ctrl_to_word(ctrl);
            default:    bus_rdata = '0;
        endcase
    end

    // R3: locked control writes change nothing
    a_r3_locked_ctrl: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !unlocked && sel == SEL_CTRL && !pulse_done) |=> (ctrl == $past(ctrl)));

    // R3: locked load writes do not reload
    a_r3_locked_load: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !unlocked && sel == SEL_LOAD && !ctrl.cnt_en && !pulse_done) |=> $stable(count));

    // R7: terminal state gives the reset pulse on the next edge
    a_r7_fire: assert property (@(posedge clk) disable iff (rst)
        (terminal && !wdt_rst_o) |=> wdt_rst_o);

    // R8: no pulse starts unless both enables were set
    a_r8_no_fire: assert property (@(posedge clk) disable iff (rst)
        (!wdt_rst_o && !(ctrl.cnt_en && ctrl.rst_en)) |=> !wdt_rst_o);

    // R10: the end of the pulse leaves everything cleared
    a_r10_cleared: assert property (@(posedge clk) disable iff (rst)
        $fell(wdt_rst_o) |-> (!unlocked && at_zero && ctrl == '0));

endmodule

// File: tb/keyed_wdt_tb_top.sv
module keyed_wdt_tb_top;

    localparam int          CNT_W = 8;
    localparam int          PLEN  = 4;
    localparam logic [31:0] KEY   = 32'h0000_482E;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_rst_o;

    int errors = 0;
    int checks = 0;
    bit hung = 1'b0;

    always #5 clk = ~clk;

    keyed_wdt #(.CNT_W(CNT_W), .PULSE_LEN(PLEN), .KEY_VAL(KEY)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wdt_rst_o (wdt_rst_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_pulse_end();
        int guard = 0;
        while (wdt_rst_o && guard < 100) begin
            @(negedge clk);
            guard++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        hung = 1'b1;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] v2;
        logic [31:0] bad_keys [5];
        bad_keys[0] = 32'h0; bad_keys[1] = 32'h0000_482F; bad_keys[2] = 32'h0001_482E;
        bad_keys[3] = 32'hFFFF_FFFF; bad_keys[4] = 32'h0000_2E48;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, v); chk("R1 unlock read", v, 0);
        rd(2'd1, v); chk("R1 counter read", v, 0);
        rd(2'd2, v); chk("R1 ctrl read", v, 0);
        chk("R1 rst_o low", {31'b0, wdt_rst_o}, 0);

        // R3 locked writes ignored
        wr(2'd1, 32'd7); wr(2'd2, 32'd5);
        rd(2'd1, v); chk("R3 locked load", v, 0);
        rd(2'd2, v); chk("R3 locked ctrl", v, 0);
        repeat (3) @(negedge clk);
        chk("R3 no pulse", {31'b0, wdt_rst_o}, 0);

        // R2 near-miss keys keep it locked
        for (int i = 0; i < 5; i++) begin
            wr(2'd0, bad_keys[i]);
            rd(2'd0, v); chk("R2 bad key stays locked", v, 0);
        end
        wr(2'd0, KEY);
        rd(2'd0, v); chk("R2 key unlocks", v, 1);

        // R5 load truncated to counter width, then decrement
        wr(2'd1, 32'h0000_1234);
        rd(2'd1, v); chk("R5 load read back", v, 32'h34);
        wr(2'd2, 32'h4);
        rd(2'd2, v); chk("R4 count enable bit2", v, 32'h4);
        rd(2'd1, v); chk("R5 value at enable", v, 32'h34);
        repeat (10) @(negedge clk);
        rd(2'd1, v); chk("R5 ten steps", v, 32'h34 - 10);

        // R6 hold with count enable clear
        wr(2'd2, 32'h0);
        rd(2'd1, v);
        repeat (5) @(negedge clk);
        rd(2'd1, v2); chk("R6 hold", v2, v);

        // R4 other bits ignored
        wr(2'd2, 32'hFFFF_FFFA);
        rd(2'd2, v); chk("R4 only bits 0,2 stored", v, 0);
        wr(2'd2, 32'hFFFF_FFFB);
        rd(2'd2, v); chk("R4 reset enable bit0", v, 1);

        // R8 reset enable alone at zero
        wr(2'd1, 32'd0);
        repeat (4) @(negedge clk);
        chk("R8 rst_en only", {31'b0, wdt_rst_o}, 0);
        // R8 count enable alone reaching zero
        wr(2'd1, 32'd3); wr(2'd2, 32'h4);
        repeat (8) @(negedge clk);
        rd(2'd1, v); chk("R5 held at zero", v, 0);
        chk("R8 cnt_en only", {31'b0, wdt_rst_o}, 0);
        wr(2'd2, 32'h0);

        // R3 relock then write ignored
        wr(2'd0, 32'h1);
        rd(2'd0, v); chk("R2 relock", v, 0);
        wr(2'd2, 32'h5);
        rd(2'd2, v); chk("R3 ctrl after relock", v, 0);

        // R7 load 0 while running gives immediate pulse
        wr(2'd0, KEY);
        wr(2'd1, 32'd200); wr(2'd2, 32'h5);
        wr(2'd1, 32'd0);
        chk("R7 not yet", {31'b0, wdt_rst_o}, 0);
        @(negedge clk);
        chk("R7 immediate pulse", {31'b0, wdt_rst_o}, 1);

        // R9 writes during pulse ignored
        wr(2'd1, 32'd9);
        rd(2'd1, v); chk("R9 load during pulse", v, 0);
        chk("R9 still in pulse", {31'b0, wdt_rst_o}, 1);
        wait_pulse_end();
        rd(2'd0, v); chk("R10 locked after", v, 0);
        rd(2'd1, v); chk("R10 counter after", v, 0);

        // R7 R9 R10 exhaustive sweep of load values
        for (int n = 0; n < (1 << CNT_W); n++) begin
            int cyc;
            int w;
            wr(2'd0, KEY);
            wr(2'd1, 32'(n));
            wr(2'd2, 32'h5);
            cyc = 0;
            while (!wdt_rst_o && cyc < 1000) begin
                @(negedge clk);
                cyc++;
            end
            chk("R7 latency", 32'(cyc), 32'(n + 1));
            w = 0;
            while (wdt_rst_o && w < 100) begin
                @(negedge clk);
                w++;
            end
            chk("R9 width", 32'(w), 32'(PLEN));
            rd(2'd0, v); chk("R10 unlock cleared", v, 0);
            rd(2'd1, v); chk("R10 counter cleared", v, 0);
            rd(2'd2, v); chk("R10 ctrl cleared", v, 0);
        end

        if (!hung) begin
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule